// File: doc/BRIEF.md
# Exception Entry and Return Controller

This block sequences the status changes a small processor core makes when it takes an exception and when it comes back from one. It holds the current status word: four condition flags, two interrupt masks, the narrow/wide instruction state bit and a five-bit mode field. It also holds one saved copy of the status for each privileged mode. Seven request sources compete for entry: a reset request, undefined instruction, software interrupt, prefetch abort, data abort, IRQ and FIQ. The two interrupt lines are honoured only while their mask bit is clear.

Accepting a request starts a one-cycle entry transaction. The block issues the link value and the target mode for the register file, loads the program counter with the vector, saves the old status into the target mode's bank and forces the new status. The state bit is cleared, the mode is forced and the masks are set. A return request starts a one-cycle return transaction. It loads the program counter from the supplied link value minus an offset, chosen by the kind of exception that last entered the current mode. It then copies the saved status back, which brings back the state bit held before the exception. Software writes to the status are filtered so that reserved bits stay zero. A write carrying an invalid mode locks the block until a reset request arrives.

The controller is a four-state machine. ST_IDLE accepts requests. ST_ENTER is the single entry cycle and ST_RETURN the single return cycle; both go back to ST_IDLE. ST_LOCKED leaves only through a reset request, which goes to ST_ENTER. The transitions out of ST_IDLE are: take-exception to ST_ENTER, accept-return to ST_RETURN, and bad-mode write to ST_LOCKED.

Top module: `trap_sequencer`

## Requirements
- R1: After rst_n is released the status reads 0x000000D3 (supervisor mode, both masks set, state bit 0, flags 0), lockup is 0, and pc_we and link_we are 0.
- R2: Status layout: N=31, Z=30, C=29, V=28, I=7, F=6, T=5, mode=4..0. A wr_en with a valid mode updates bits 31..28 and 7..0 at the next edge, and bits 27..8 always read 0.
- R3: The valid modes are user 0x10, FIQ 0x11, IRQ 0x12, supervisor 0x13, abort 0x17, undefined 0x1B and system 0x1F. A write with any other mode leaves the status unchanged and raises lockup. Lockup stays 1 and all requests, returns and writes are ignored until req_reset, whose entry clears lockup.
- R4: When several requests are accepted together, priority runs reset, data abort, FIQ, IRQ, prefetch abort, then undefined or software interrupt.
- R5: IRQ is taken only while I=0 and FIQ only while F=0; a masked request changes neither the status nor the outputs.
- R6: The cycle after a request is accepted, pc_we pulses for one cycle with pc_val = VEC_BASE plus 0x00 reset, 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 IRQ or 0x1C FIQ. In the same cycle link_we pulses with link_val = pc_in+8 for data abort or pc_in+4 otherwise, and link_mode gives the target mode.
- R7: At the end of the entry cycle the mode becomes the target mode (reset and software interrupt go to supervisor, both aborts to abort, undefined to undefined, IRQ to IRQ, FIQ to FIQ). T is cleared, I is set, F is set for reset and FIQ only, and the flags are kept. The prior status is saved in the target mode's bank.
- R8: ret_req in a privileged mode other than system causes a one-cycle pc_we the next cycle, with pc_val = lr_in minus 0 (reset, undefined, software interrupt), 4 (prefetch abort, IRQ, FIQ) or 8 (data abort), according to the last entry into that mode. At the following edge the status becomes that mode's saved copy, T included.
- R9: ret_req in user or system mode has no effect.
- R10: In one cycle an accepted exception beats a return, which beats a write. All requests, returns and writes arriving during an entry or return cycle are ignored.
- R11: Undefined instruction enters undefined mode at offset 0x04 and software interrupt enters supervisor mode at offset 0x08; the two requests are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_reset | input | 1 | Reset exception request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_dabt | input | 1 | Data abort request |
| irq | input | 1 | Normal interrupt request |
| fiq | input | 1 | Fast interrupt request |
| pc_in | input | PC_W | Program counter of the interrupted point |
| ret_req | input | 1 | Exception return request |
| lr_in | input | PC_W | Link value of the current mode for a return |
| wr_en | input | 1 | Software status write strobe |
| wr_data | input | 32 | Software status write value |
| status | output | 32 | Current status word |
| lockup | output | 1 | Sticky invalid-mode lockup |
| pc_we | output | 1 | Program counter load strobe |
| pc_val | output | PC_W | Program counter load value |
| link_we | output | 1 | Link register write strobe |
| link_val | output | PC_W | Link register write value |
| link_mode | output | 5 | Mode whose link register is written |

## Verification
The main sweep covers every combination of the seven request lines, except undefined and software interrupt together, against every setting of I, F and T and a changing flag pattern. This separates priority errors from masking errors and shows whether T and the flags survive a full entry and return. Each trial is closed by a return, so the per-kind link and return offsets and the saved bank contents are checked on every accepted kind. Directed patterns then pit an exception against a same-cycle return and write, raise requests during the busy cycle, issue returns from user and system mode, write all-ones to the reserved bits, and drive the block into lockup and out through a reset request.

// File: rtl/trap_pkg.sv
package trap_pkg;

    localparam int STAT_W   = 32;
    localparam int MODE_W   = 5;
    localparam int KIND_W   = 3;
    localparam int N_BANKS  = 5;
    localparam int BANK_IW  = $clog2(N_BANKS);

    localparam int BIT_I    = 7;
    localparam int BIT_F    = 6;
    localparam int BIT_T    = 5;

    localparam logic [STAT_W-1:0] WR_MASK    = 32'hF000_00FF;
    localparam logic [STAT_W-1:0] RST_STATUS = 32'h0000_00D3;

    localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
    localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
    localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
    localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
    localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

    typedef enum logic [KIND_W-1:0] {
        K_RESET = 3'd0,
        K_UNDEF = 3'd1,
        K_SWI   = 3'd2,
        K_PABT  = 3'd3,
        K_DABT  = 3'd4,
        K_IRQ   = 3'd5,
        K_FIQ   = 3'd6
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ENTER,
        ST_RETURN,
        ST_LOCKED
    } seq_state_e;

    function automatic logic mode_valid(input logic [MODE_W-1:0] m);
        return (m == MODE_USR) || (m == MODE_FIQ) || (m == MODE_IRQ) ||
               (m == MODE_SVC) || (m == MODE_ABT) || (m == MODE_UND) ||
               (m == MODE_SYS);
    endfunction

    function automatic logic [MODE_W-1:0] kind_mode(input kind_e k);
        logic [MODE_W-1:0] m;
        unique case (k)
            K_RESET, K_SWI: m = MODE_SVC;
            K_UNDEF:        m = MODE_UND;
            K_PABT, K_DABT: m = MODE_ABT;
            K_IRQ:          m = MODE_IRQ;
            K_FIQ:          m = MODE_FIQ;
            default:        m = MODE_SVC;
        endcase
        return m;
    endfunction

    function automatic logic [7:0] kind_vec_off(input kind_e k);
        logic [7:0] v;
        unique case (k)
            K_RESET: v = 8'h00;
            K_UNDEF: v = 8'h04;
            K_SWI:   v = 8'h08;
            K_PABT:  v = 8'h0C;
            K_DABT:  v = 8'h10;
            K_IRQ:   v = 8'h18;
            K_FIQ:   v = 8'h1C;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

    function automatic logic [3:0] kind_link_off(input kind_e k);
        return (k == K_DABT) ? 4'd8 : 4'd4;
    endfunction

    function automatic logic [3:0] kind_ret_off(input kind_e k);
        logic [3:0] o;
        unique case (k)
            K_RESET, K_UNDEF, K_SWI: o = 4'd0;
            K_PABT, K_IRQ, K_FIQ:    o = 4'd4;
            K_DABT:                  o = 4'd8;
            default:                 o = 4'd0;
        endcase
        return o;
    endfunction

    function automatic logic has_bank(input logic [MODE_W-1:0] m);
        return (m == MODE_FIQ) || (m == MODE_IRQ) || (m == MODE_SVC) ||
               (m == MODE_ABT) || (m == MODE_UND);
    endfunction

    function automatic logic [BANK_IW-1:0] bank_idx(input logic [MODE_W-1:0] m);
        logic [BANK_IW-1:0] b;
        unique case (m)
            MODE_FIQ: b = BANK_IW'(0);
            MODE_IRQ: b = BANK_IW'(1);
            MODE_SVC: b = BANK_IW'(2);
            MODE_ABT: b = BANK_IW'(3);
            MODE_UND: b = BANK_IW'(4);
            default:  b = BANK_IW'(2);
        endcase
        return b;
    endfunction

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_pkg::*;
(
    input  logic  en_all,
    input  logic  en_reset,
    input  logic  mask_i,
    input  logic  mask_f,
    input  logic  r_reset,
    input  logic  r_undef,
    input  logic  r_swi,
    input  logic  r_pabt,
    input  logic  r_dabt,
    input  logic  r_irq,
    input  logic  r_fiq,
    output logic  take,
    output kind_e kind
);

    always_comb begin
        take = 1'b1;
        kind = K_RESET;
        if (r_reset && en_reset) begin
            kind = K_RESET;
        end else if (!en_all) begin
            take = 1'b0;
        end else if (r_dabt) begin
            kind = K_DABT;
        end else if (r_fiq && !mask_f) begin
            kind = K_FIQ;
        end else if (r_irq && !mask_i) begin
            kind = K_IRQ;
        end else if (r_pabt) begin
            kind = K_PABT;
        end else if (r_undef) begin
            kind = K_UNDEF;
        end else if (r_swi) begin
            kind = K_SWI;
        end else begin
            take = 1'b0;
        end
    end

endmodule

// File: rtl/trap_bank.sv
module trap_bank
    import trap_pkg::*;
#(
    parameter int NB = N_BANKS,
    parameter int W  = STAT_W,
    parameter int KW = KIND_W,
    localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [W-1:0]  wstat,
    input  logic [KW-1:0] wkind,
    input  logic [IW-1:0] ridx,
    output logic [W-1:0]  rstat,
    output logic [KW-1:0] rkind
);

    logic [W-1:0]  stat_q [NB];
    logic [KW-1:0] kind_q [NB];

    for (genvar g = 0; g < NB; g++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stat_q[g] <= '0;
                kind_q[g] <= '0;
            end else if (we && (widx == IW'(g))) begin
                stat_q[g] <= wstat;
                kind_q[g] <= wkind;
            end
        end
    end

    always_comb begin
        rstat = '0;
        rkind = '0;
        for (int i = 0; i < NB; i++) begin
            if (ridx == IW'(i)) begin
                rstat = stat_q[i];
                rkind = kind_q[i];
            end
        end
    end

endmodule

// File: rtl/trap_entry_calc.sv
module trap_entry_calc
    import trap_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input  kind_e              kind,
    input  logic [STAT_W-1:0]  cur_stat,
    input  logic [PC_W-1:0]    pc,
    output logic [STAT_W-1:0]  new_stat,
    output logic [PC_W-1:0]    vec,
    output logic [PC_W-1:0]    link,
    output logic [MODE_W-1:0]  tgt_mode
);

    logic set_f;

    always_comb begin
        tgt_mode = kind_mode(kind);
        set_f    = (kind == K_RESET) || (kind == K_FIQ);
        new_stat = '0;
        new_stat[STAT_W-1:STAT_W-4] = cur_stat[STAT_W-1:STAT_W-4];
        new_stat[BIT_I]             = 1'b1;
        new_stat[BIT_F]             = set_f | cur_stat[BIT_F];
        new_stat[BIT_T]             = 1'b0;
        new_stat[MODE_W-1:0]        = tgt_mode;
        vec  = VEC_BASE + PC_W'(kind_vec_off(kind));
        link = pc + PC_W'(kind_link_off(kind));
    end

endmodule

// File: rtl/trap_sequencer.sv
module trap_sequencer
    import trap_pkg::*;
#(
    parameter int              PC_W     = 32,
    parameter logic [PC_W-1:0] VEC_BASE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_undef,
    input  logic              req_swi,
    input  logic              req_pabt,
    input  logic              req_dabt,
    input  logic              irq,
    input  logic              fiq,
    input  logic [PC_W-1:0]   pc_in,
    input  logic              ret_req,
    input  logic [PC_W-1:0]   lr_in,
    input  logic              wr_en,
    input  logic [STAT_W-1:0] wr_data,
    output logic [STAT_W-1:0] status,
    output logic              lockup,
    output logic              pc_we,
    output logic [PC_W-1:0]   pc_val,
    output logic              link_we,
    output logic [PC_W-1:0]   link_val,
    output logic [MODE_W-1:0] link_mode
);

    seq_state_e state_q, state_d;

    logic [STAT_W-1:0] cpsr_q;
    kind_e             kind_q;
    logic [PC_W-1:0]   pc_q;
    logic [PC_W-1:0]   lr_q;

    logic              take;
    kind_e             take_kind;
    logic              ret_ok;
    logic              wr_bad;

    logic [STAT_W-1:0] ent_stat;
    logic [PC_W-1:0]   ent_vec;
    logic [PC_W-1:0]   ent_link;
    logic [MODE_W-1:0] ent_mode;

    logic [STAT_W-1:0] sav_stat;
    logic [KIND_W-1:0] sav_kind;
    logic              bank_we;

    // Request selection: everything in idle, only reset while locked.
    trap_arbiter u_arb (
        .en_all   (state_q == ST_IDLE),
        .en_reset ((state_q == ST_IDLE) || (state_q == ST_LOCKED)),
        .mask_i   (cpsr_q[BIT_I]),
        .mask_f   (cpsr_q[BIT_F]),
        .r_reset  (req_reset),
        .r_undef  (req_undef),
        .r_swi    (req_swi),
        .r_pabt   (req_pabt),
        .r_dabt   (req_dabt),
        .r_irq    (irq),
        .r_fiq    (fiq),
        .take     (take),
        .kind     (take_kind)
    );

    trap_entry_calc #(
        .PC_W     (PC_W),
        .VEC_BASE (VEC_BASE)
    ) u_calc (
        .kind     (kind_q),
        .cur_stat (cpsr_q),
        .pc       (pc_q),
        .new_stat (ent_stat),
        .vec      (ent_vec),
        .link     (ent_link),
        .tgt_mode (ent_mode)
    );

    assign bank_we = (state_q == ST_ENTER);

    trap_bank #(
        .NB (N_BANKS),
        .W  (STAT_W),
        .KW (KIND_W)
    ) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (bank_we),
        .widx  (bank_idx(ent_mode)),
        .wstat (cpsr_q),
        .wkind (kind_q),
        .ridx  (bank_idx(cpsr_q[MODE_W-1:0])),
        .rstat (sav_stat),
        .rkind (sav_kind)
    );

    assign ret_ok = ret_req && has_bank(cpsr_q[MODE_W-1:0]);
    assign wr_bad = wr_en && !mode_valid(wr_data[MODE_W-1:0]);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (take)        state_d = ST_ENTER;
                else if (ret_ok) state_d = ST_RETURN;
                else if (wr_bad) state_d = ST_LOCKED;
                else             state_d = ST_IDLE;
            end
            ST_ENTER:  state_d = ST_IDLE;
            ST_RETURN: state_d = ST_IDLE;
            ST_LOCKED: state_d = take ? ST_ENTER : ST_LOCKED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Status and transaction data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpsr_q <= RST_STATUS;
            kind_q <= K_RESET;
            pc_q   <= '0;
            lr_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (take) begin
                        kind_q <= take_kind;
                        pc_q   <= pc_in;
                    end else if (ret_ok) begin
                        lr_q   <= lr_in;
                    end else if (wr_en && !wr_bad) begin
                        cpsr_q <= wr_data & WR_MASK;
                    end
                end
                ST_ENTER:  cpsr_q <= ent_stat;
                ST_RETURN: cpsr_q <= sav_stat;
                ST_LOCKED: begin
                    if (take) begin
                        kind_q <= take_kind;
                        pc_q   <= pc_in;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        pc_we     = 1'b0;
        pc_val    = '0;
        link_we   = 1'b0;
        link_val  = '0;
        link_mode = '0;
        lockup    = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ENTER: begin
                pc_we     = 1'b1;
                pc_val    = ent_vec;
                link_we   = 1'b1;
                link_val  = ent_link;
                link_mode = ent_mode;
            end
            ST_RETURN: begin
                pc_we  = 1'b1;
                pc_val = lr_q - PC_W'(kind_ret_off(kind_e'(sav_kind)));
            end
            ST_LOCKED: lockup = 1'b1;
            default: ;
        endcase
    end

    assign status = cpsr_q;

endmodule

// File: rtl/trap_sequencer_chk.sv
module trap_sequencer_chk
    import trap_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              req_reset,
    input logic              req_undef,
    input logic              req_swi,
    input logic [STAT_W-1:0] status,
    input logic              lockup,
    input logic              pc_we,
    input logic              link_we,
    input logic [MODE_W-1:0] link_mode
);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        status[27:8] == 20'h0);

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_valid(status[MODE_W-1:0]));

    // R3
    lockup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lockup && !req_reset) |=> lockup);

    // R3
    lockup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lockup |-> (!pc_we && !link_we));

    // R6
    pc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> !pc_we);

    // R6
    link_with_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> pc_we);

    // R7
    entry_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |=> (!status[BIT_T] && status[BIT_I] &&
                     status[MODE_W-1:0] == $past(link_mode)));

    // R7
    fiq_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && link_mode == MODE_FIQ) |=> status[BIT_F]);

    // R11
    undef_swi_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_undef && req_swi));

endmodule

bind trap_sequencer trap_sequencer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_reset (req_reset),
    .req_undef (req_undef),
    .req_swi   (req_swi),
    .status    (status),
    .lockup    (lockup),
    .pc_we     (pc_we),
    .link_we   (link_we),
    .link_mode (link_mode)
);

// File: tb/trap_sequencer_tb.sv
`timescale 1ns/1ps
module trap_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_reset = 0, req_undef = 0, req_swi = 0, req_pabt = 0;
    logic        req_dabt = 0, irq = 0, fiq = 0;
    logic [31:0] pc_in = '0;
    logic        ret_req = 0;
    logic [31:0] lr_in = '0;
    logic        wr_en = 0;
    logic [31:0] wr_data = '0;
    logic [31:0] status;
    logic        lockup;
    logic        pc_we;
    logic [31:0] pc_val;
    logic        link_we;
    logic [31:0] link_val;
    logic [4:0]  link_mode;

    int vectors = 0;
    int fails = 0;

    always #2 clk = ~clk;

    trap_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_undef(req_undef), .req_swi(req_swi),
        .req_pabt(req_pabt), .req_dabt(req_dabt), .irq(irq), .fiq(fiq),
        .pc_in(pc_in), .ret_req(ret_req), .lr_in(lr_in),
        .wr_en(wr_en), .wr_data(wr_data),
        .status(status), .lockup(lockup), .pc_we(pc_we), .pc_val(pc_val),
        .link_we(link_we), .link_val(link_val), .link_mode(link_mode)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act,
                          input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    // kind codes: 0 reset,1 undef,2 swi,3 pabt,4 dabt,5 irq,6 fiq, -1 none
    function automatic int pick(input logic [6:0] r, input bit i, input bit f);
        if (r[0]) return 0;
        if (r[4]) return 4;
        if (r[6] && !f) return 6;
        if (r[5] && !i) return 5;
        if (r[3]) return 3;
        if (r[1]) return 1;
        if (r[2]) return 2;
        return -1;
    endfunction

    function automatic logic [4:0] mode_of(input int k);
        case (k)
            0, 2: return 5'h13;
            1:    return 5'h1B;
            3, 4: return 5'h17;
            5:    return 5'h12;
            default: return 5'h11;
        endcase
    endfunction

    function automatic logic [31:0] vec_of(input int k);
        case (k)
            0: return 32'h00; 1: return 32'h04; 2: return 32'h08;
            3: return 32'h0C; 4: return 32'h10; 5: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction

    task automatic drive_req(input logic [6:0] r);
        req_reset = r[0]; req_undef = r[1]; req_swi = r[2]; req_pabt = r[3];
        req_dabt = r[4]; irq = r[5]; fiq = r[6];
    endtask

    // Called at a negedge; returns at the negedge after the write edge.
    task automatic do_write(input logic [31:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_return(input logic [31:0] lr, input string tag,
                             input logic [31:0] exp_pc,
                             input logic [31:0] exp_stat);
        ret_req = 1'b1; lr_in = lr;
        @(negedge clk);
        ret_req = 1'b0;
        chk_eq({tag, " ret pc_we"}, {31'b0, pc_we}, 32'd1);
        chk_eq({tag, " ret pc_val"}, pc_val, exp_pc);
        @(negedge clk);
        chk_eq({tag, " ret status"}, status, exp_stat);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        fails++;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_eq("R1 status", status, 32'h0000_00D3);
        chk_eq("R1 lockup", {31'b0, lockup}, 32'd0);
        chk_eq("R1 pulses", {30'b0, pc_we, link_we}, 32'd0);

        // R2 reserved bits cannot be set
        do_write(32'hFFFF_FFFF);
        chk_eq("R2 reserved write", status, 32'hF000_00FF);

        // R9 return from system and user ignored
        ret_req = 1'b1; lr_in = 32'h400;
        @(negedge clk);
        ret_req = 1'b0;
        chk_eq("R9 sys ret pc_we", {31'b0, pc_we}, 32'd0);
        @(negedge clk);
        chk_eq("R9 sys status", status, 32'hF000_00FF);
        do_write(32'h0000_0010);
        ret_req = 1'b1;
        @(negedge clk);
        ret_req = 1'b0;
        chk_eq("R9 usr ret pc_we", {31'b0, pc_we}, 32'd0);
        @(negedge clk);
        chk_eq("R9 usr status", status, 32'h0000_0010);

        // Main sweep: R4 R5 R6 R7 R8 R11
        for (int t = 0; t < 2; t++) begin
            for (int im = 0; im < 2; im++) begin
                for (int fm = 0; fm < 2; fm++) begin
                    for (int r = 0; r < 128; r++) begin
                        logic [6:0]  rv;
                        logic [31:0] pre, pcv, expst, explink, expret;
                        int k;
                        rv = 7'(r);
                        if (rv[1] && rv[2]) continue;
                        pre = {4'(r * 7 + t), 20'h0, im[0], fm[0], t[0], 5'h10};
                        pcv = 32'h0000_1000 + 32'(r) * 32'h40 + 32'(t * 8);
                        do_write(pre);
                        chk_eq("R2 write", status, pre);
                        k = pick(rv, im[0], fm[0]);
                        pc_in = pcv;
                        drive_req(rv);
                        @(negedge clk);
                        drive_req(7'h0);
                        if (k < 0) begin
                            chk_eq("R5 no entry pc_we", {31'b0, pc_we}, 32'd0);
                            @(negedge clk);
                            chk_eq("R5 status kept", status, pre);
                            continue;
                        end
                        explink = pcv + ((k == 4) ? 32'd8 : 32'd4);
                        chk_eq("R6 pc_we", {31'b0, pc_we}, 32'd1);
                        chk_eq("R4 R6 vector", pc_val, vec_of(k));
                        chk_eq("R6 link_we", {31'b0, link_we}, 32'd1);
                        chk_eq("R6 link_val", link_val, explink);
                        chk_eq("R11 R6 link_mode", {27'b0, link_mode},
                               {27'b0, mode_of(k)});
                        @(negedge clk);
                        chk_eq("R6 pulse ends", {31'b0, pc_we}, 32'd0);
                        expst = {pre[31:28], 20'h0, 1'b1,
                                 (k == 0 || k == 6) ? 1'b1 : pre[6], 1'b0,
                                 mode_of(k)};
                        chk_eq("R7 entry status", status, expst);
                        expret = (k == 0 || k == 1 || k == 2) ? pcv + 32'd4 : pcv;
                        do_return(explink, "R8", expret, pre);
                    end
                end
            end
        end

        // R10 precedence: exception over return and write
        do_write(32'h0000_0010);
        pc_in = 32'h2000;
        irq = 1'b1; ret_req = 1'b1; wr_en = 1'b1; wr_data = 32'hF000_001F;
        @(negedge clk);
        irq = 1'b0; ret_req = 1'b0; wr_en = 1'b0;
        chk_eq("R10 irq wins", pc_val, 32'h18);
        @(negedge clk);
        chk_eq("R10 write dropped", status, 32'h0000_0092);
        // nested: software interrupt from IRQ mode
        pc_in = 32'h3000;
        req_swi = 1'b1;
        @(negedge clk);
        req_swi = 1'b0;
        // R10 fiq raised during the entry cycle is ignored
        fiq = 1'b1;
        chk_eq("R11 swi vector", pc_val, 32'h08);
        @(negedge clk);
        fiq = 1'b0;
        chk_eq("R10 busy ignored pc_we", {31'b0, pc_we}, 32'd0);
        chk_eq("R10 busy ignored status", status, 32'h0000_0093);
        // return beats write
        ret_req = 1'b1; lr_in = 32'h3004; wr_en = 1'b1; wr_data = 32'h0000_001F;
        @(negedge clk);
        ret_req = 1'b0; wr_en = 1'b0;
        chk_eq("R10 ret wins pc", pc_val, 32'h3004);
        @(negedge clk);
        chk_eq("R8 nested restore", status, 32'h0000_0092);
        do_return(32'h2004, "R8 outer", 32'h2000, 32'h0000_0010);

        // R3 lockup
        do_write(32'h0000_0005);
        chk_eq("R3 lockup set", {31'b0, lockup}, 32'd1);
        chk_eq("R3 status kept", status, 32'h0000_0010);
        irq = 1'b1;
        @(negedge clk);
        irq = 1'b0;
        chk_eq("R3 irq ignored", {31'b0, pc_we}, 32'd0);
        do_write(32'h0000_0013);
        chk_eq("R3 write ignored", status, 32'h0000_0010);
        chk_eq("R3 still locked", {31'b0, lockup}, 32'd1);
        req_reset = 1'b1; pc_in = 32'h500;
        @(negedge clk);
        req_reset = 1'b0;
        chk_eq("R3 reset vector", pc_val, 32'h0);
        chk_eq("R3 lockup cleared", {31'b0, lockup}, 32'd0);
        @(negedge clk);
        chk_eq("R3 R7 reset status", status, 32'h0000_00D3);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule